// File: doc/BRIEF.md
# AU-4 Pointer Interpreter

This block follows the administrative-unit pointer of a synchronous transport frame and keeps an up-to-date record of where the high-order virtual container starts. Once per frame the receive framer presents the 16-bit pointer word together with a one-cycle strobe. The interpreter sorts the frame into one of five classes: steady, increment, decrement, out-of-range or candidate new value. It then maintains an active pointer. From that pointer it derives the byte offset of the container's first byte, counted from the end of the fourth overhead row.

A new plain value is taken only after it has arrived in three frames in a row. A justification is recognised by a majority vote over the interleaved increment and decrement bits, compared against the active value. Each accepted justification produces a single-cycle pulse, which marks the frame whose stuff-opportunity byte must be skipped or read as data. A justification that arrives too soon after the previous pointer change is discarded and reported. Payload extraction and full loss-of-pointer handling belong to other blocks.

Top module: `au4_ptr_interp`

## Requirements
- R1: After reset the active pointer and the byte offset are 0, and the increment, decrement, reject and invalid outputs are all low.
- R2: The value is `ptr_word[9:0]`. A value in the range 0..782 that is not a justification, and that differs from the active pointer, becomes the active pointer on the third consecutive frame that carries it. Two such frames, or a run broken by any other frame, leave the active pointer unchanged.
- R3: The increment bits are positions 9, 7, 5, 3 and 1, and the decrement bits are positions 8, 6, 4, 2 and 0. Once a value has been accepted, a frame with 3 or more increment bits differing from the active pointer and fewer than 3 decrement bits differing adds one to the active pointer, wrapping from 782 to 0. It also raises `inc_pulse` for one cycle.
- R4: Once a value has been accepted, a frame with 3 or more decrement bits differing and fewer than 3 increment bits differing subtracts one from the active pointer, wrapping from 0 to 782. It also raises `dec_pulse` for one cycle.
- R5: `vc_offset` always equals three times the active pointer, so 87 gives 261.
- R6: An increment or decrement frame is acted on only if at least three frames have passed since the last adjustment or acceptance. Otherwise the active pointer is unchanged and `adj_reject` pulses for one cycle.
- R7: A frame whose value exceeds 782 and which is not a justification sets `ptr_invalid`, leaves the active pointer unchanged and breaks any run toward a new value. `ptr_invalid` stays set until the next frame that is not out of range.
- R8: Outputs change one clock after a strobed frame. A frame equal to the active pointer, or a cycle without strobe, changes nothing and raises no pulse.
- R9: Before any value has been accepted, justification patterns are treated as plain values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_stb | input | 1 | One-cycle strobe: pointer word of a frame is present |
| ptr_word | input | 16 | Received pointer word; value in bits 9..0 |
| active_ptr | output | 10 | Active pointer value |
| vc_offset | output | 12 | Container start offset in bytes |
| inc_pulse | output | 1 | Accepted positive justification |
| dec_pulse | output | 1 | Accepted negative justification |
| adj_reject | output | 1 | Justification discarded for arriving too early |
| ptr_invalid | output | 1 | Last frame carried an out-of-range value |

## Verification
The hardest state to reach is a justification that arrives exactly at the edge of the guard window just after a new value was accepted. Reaching it needs a lock, then a precise count of steady frames, then a bit-inverted word built from the current active value. The bench tracks the active value in its own model, so it can build increment and decrement words from it. It places them zero to four frames after each change, and does this both at the wrap points 0 and 782 and in a long randomised stretch. Out-of-range words whose increment and decrement bits both flip a majority are used to reach the invalid path without being taken as justifications.

// File: rtl/au4_ptr_pkg.sv
package au4_ptr_pkg;

   typedef enum logic [2:0] {
      FC_STEADY = 3'd0,
      FC_INC    = 3'd1,
      FC_DEC    = 3'd2,
      FC_BAD    = 3'd3,
      FC_NEW    = 3'd4
   } frame_cls_e;

   function automatic int unsigned half_up(input int unsigned n);
      return (n / 2) + 1;
   endfunction

endpackage

// File: rtl/au4_ptr_classify.sv
module au4_ptr_classify
   import au4_ptr_pkg::*;
#(
   parameter int PTR_W   = 10,
   parameter int MAX_PTR = 782
) (
   input  logic [PTR_W-1:0] rx_val,
   input  logic [PTR_W-1:0] act_val,
   input  logic             locked,
   output frame_cls_e       cls
);
   localparam int PAIRS = PTR_W / 2;
   localparam int MAJ   = int'(half_up(PAIRS));
   localparam int CNT_W = $clog2(PAIRS + 1);

   logic [PAIRS-1:0] up_diff;
   logic [PAIRS-1:0] dn_diff;
   logic [CNT_W-1:0] up_cnt;
   logic [CNT_W-1:0] dn_cnt;
   logic             up_flip;
   logic             dn_flip;

   for (genvar k = 0; k < PAIRS; k++) begin : g_pair
      assign up_diff[k] = rx_val[2*k+1] ^ act_val[2*k+1];
      assign dn_diff[k] = rx_val[2*k]   ^ act_val[2*k];
   end

   assign up_cnt  = CNT_W'($countones(up_diff));
   assign dn_cnt  = CNT_W'($countones(dn_diff));
   assign up_flip = (up_cnt >= CNT_W'(MAJ));
   assign dn_flip = (dn_cnt >= CNT_W'(MAJ));

   always_comb begin
      if (locked && up_flip && !dn_flip)
         cls = FC_INC;
      else if (locked && dn_flip && !up_flip)
         cls = FC_DEC;
      else if (rx_val > PTR_W'(MAX_PTR))
         cls = FC_BAD;
      else if (locked && (rx_val == act_val))
         cls = FC_STEADY;
      else
         cls = FC_NEW;
   end

endmodule

// File: rtl/au4_ptr_guard.sv
module au4_ptr_guard #(
   parameter int GUARD = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic advance,
   input  logic restart,
   output logic open
);
   localparam int GW = $clog2(GUARD + 1);

   logic [GW-1:0] gap_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         gap_q <= GW'(GUARD);
      else if (restart)
         gap_q <= '0;
      else if (advance && (gap_q < GW'(GUARD)))
         gap_q <= gap_q + 1'b1;
   end

   assign open = (gap_q >= GW'(GUARD));

endmodule

// File: rtl/au4_ptr_confirm.sv
module au4_ptr_confirm #(
   parameter int PTR_W     = 10,
   parameter int N_CONFIRM = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_new,
   input  logic             clear,
   input  logic [PTR_W-1:0] rx_val,
   output logic             accept
);
   localparam int CW = $clog2(N_CONFIRM + 1);

   logic [PTR_W-1:0] cand_q;
   logic [CW-1:0]    run_q;
   logic [CW-1:0]    run_nx;
   logic             same;

   assign same   = (run_q != '0) && (rx_val == cand_q);
   assign run_nx = same ? run_q + 1'b1 : CW'(1);
   assign accept = frame_new && (run_nx == CW'(N_CONFIRM));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cand_q <= '0;
         run_q  <= '0;
      end else if (clear) begin
         run_q <= '0;
      end else if (frame_new) begin
         cand_q <= rx_val;
         run_q  <= accept ? '0 : run_nx;
      end
   end

endmodule

// File: rtl/au4_ptr_interp.sv
module au4_ptr_interp
   import au4_ptr_pkg::*;
#(
   parameter int WORD_W    = 16,
   parameter int PTR_W     = 10,
   parameter int MAX_PTR   = 782,
   parameter int OFS_MULT  = 3,
   parameter int GUARD     = 3,
   parameter int N_CONFIRM = 3,
   parameter int OFS_W     = $clog2(MAX_PTR * OFS_MULT + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_stb,
   input  logic [WORD_W-1:0] ptr_word,
   output logic [PTR_W-1:0]  active_ptr,
   output logic [OFS_W-1:0]  vc_offset,
   output logic              inc_pulse,
   output logic              dec_pulse,
   output logic              adj_reject,
   output logic              ptr_invalid
);
   localparam int MAX_OFS = MAX_PTR * OFS_MULT;

   if (PTR_W % 2 != 0)
      $error("PTR_W must be even for interleaved bit pairs");
   if (MAX_PTR >= (1 << PTR_W))
      $error("MAX_PTR does not fit in PTR_W bits");
   if (WORD_W < PTR_W)
      $error("WORD_W narrower than PTR_W");
   if (MAX_OFS >= (1 << OFS_W))
      $error("OFS_W too narrow for the offset range");
   if (GUARD < 1 || N_CONFIRM < 1)
      $error("GUARD and N_CONFIRM must be positive");

   logic [PTR_W-1:0] rx_val;
   logic [PTR_W-1:0] act_q;
   logic             locked_q;
   frame_cls_e       cls;
   logic             is_adj;
   logic             guard_open;
   logic             adj_take;
   logic             accept;
   logic [PTR_W-1:0] act_up;
   logic [PTR_W-1:0] act_dn;

   assign rx_val = ptr_word[PTR_W-1:0];

   au4_ptr_classify #(
      .PTR_W  (PTR_W),
      .MAX_PTR(MAX_PTR)
   ) u_cls (
      .rx_val (rx_val),
      .act_val(act_q),
      .locked (locked_q),
      .cls    (cls)
   );

   assign is_adj   = frame_stb && ((cls == FC_INC) || (cls == FC_DEC));
   assign adj_take = is_adj && guard_open;

   au4_ptr_guard #(
      .GUARD(GUARD)
   ) u_guard (
      .clk    (clk),
      .rst_n  (rst_n),
      .advance(frame_stb),
      .restart(adj_take || accept),
      .open   (guard_open)
   );

   au4_ptr_confirm #(
      .PTR_W    (PTR_W),
      .N_CONFIRM(N_CONFIRM)
   ) u_conf (
      .clk      (clk),
      .rst_n    (rst_n),
      .frame_new(frame_stb && (cls == FC_NEW)),
      .clear    (frame_stb && (cls != FC_NEW)),
      .rx_val   (rx_val),
      .accept   (accept)
   );

   assign act_up = (act_q == PTR_W'(MAX_PTR)) ? '0 : act_q + 1'b1;
   assign act_dn = (act_q == '0) ? PTR_W'(MAX_PTR) : act_q - 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q       <= '0;
         locked_q    <= 1'b0;
         inc_pulse   <= 1'b0;
         dec_pulse   <= 1'b0;
         adj_reject  <= 1'b0;
         ptr_invalid <= 1'b0;
      end else begin
         inc_pulse  <= 1'b0;
         dec_pulse  <= 1'b0;
         adj_reject <= 1'b0;
         if (frame_stb) begin
            ptr_invalid <= (cls == FC_BAD);
            if (is_adj && !guard_open) begin
               adj_reject <= 1'b1;
            end else if (cls == FC_INC) begin
               act_q     <= act_up;
               inc_pulse <= 1'b1;
            end else if (cls == FC_DEC) begin
               act_q     <= act_dn;
               dec_pulse <= 1'b1;
            end else if (accept) begin
               act_q    <= rx_val;
               locked_q <= 1'b1;
            end
         end
      end
   end

   assign active_ptr = act_q;

   if (OFS_MULT == 3) begin : g_ofs_shadd
      logic [OFS_W-1:0] wide;
      assign wide      = OFS_W'(act_q);
      assign vc_offset = (wide << 1) + wide;
   end else begin : g_ofs_mul
      assign vc_offset = OFS_W'(act_q) * OFS_W'(OFS_MULT);
   end

endmodule

// File: rtl/au4_ptr_interp_chk.sv
module au4_ptr_interp_chk #(
   parameter int PTR_W    = 10,
   parameter int MAX_PTR  = 782,
   parameter int OFS_MULT = 3,
   parameter int GUARD    = 3,
   parameter int OFS_W    = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             frame_stb,
   input logic [PTR_W-1:0] active_ptr,
   input logic [OFS_W-1:0] vc_offset,
   input logic             inc_pulse,
   input logic             dec_pulse,
   input logic             adj_reject,
   input logic             ptr_invalid
);
   localparam int GW = $clog2(GUARD + 2);

   logic             stb_q;
   logic [PTR_W-1:0] prev_act;
   logic [GW-1:0]    gap;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stb_q    <= 1'b0;
         prev_act <= '0;
         gap      <= GW'(GUARD);
      end else begin
         stb_q    <= frame_stb;
         prev_act <= active_ptr;
         if (active_ptr != prev_act)
            gap <= '0;
         else if (stb_q && (gap < GW'(GUARD)))
            gap <= gap + 1'b1;
      end
   end

   assert_ptr_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      active_ptr <= PTR_W'(MAX_PTR));

   assert_inc_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      inc_pulse |-> (active_ptr == (($past(active_ptr) == PTR_W'(MAX_PTR)) ?
                                    '0 : $past(active_ptr) + PTR_W'(1))));

   assert_one_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({inc_pulse, dec_pulse, adj_reject}));

   assert_dec_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      dec_pulse |-> (active_ptr == (($past(active_ptr) == '0) ?
                                    PTR_W'(MAX_PTR) : $past(active_ptr) - PTR_W'(1))));

   assert_offset_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      vc_offset <= OFS_W'(MAX_PTR * OFS_MULT));

   assert_offset_track_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(active_ptr) |-> $stable(vc_offset));

   assert_guard_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_pulse || dec_pulse) |-> (gap >= GW'(GUARD)));

   assert_reject_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      adj_reject |-> $stable(active_ptr));

   assert_invalid_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_invalid |-> ($stable(active_ptr) && !inc_pulse && !dec_pulse));

   assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(frame_stb) |-> ($stable(active_ptr) && $stable(ptr_invalid) &&
                             !inc_pulse && !dec_pulse && !adj_reject));

endmodule

bind au4_ptr_interp au4_ptr_interp_chk #(
   .PTR_W   (PTR_W),
   .MAX_PTR (MAX_PTR),
   .OFS_MULT(OFS_MULT),
   .GUARD   (GUARD),
   .OFS_W   (OFS_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .frame_stb  (frame_stb),
   .active_ptr (active_ptr),
   .vc_offset  (vc_offset),
   .inc_pulse  (inc_pulse),
   .dec_pulse  (dec_pulse),
   .adj_reject (adj_reject),
   .ptr_invalid(ptr_invalid)
);

// File: tb/tb_au4_ptr_interp.sv
module tb_au4_ptr_interp;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_stb = 1'b0;
   logic [15:0] ptr_word = '0;
   logic [9:0]  active_ptr;
   logic [11:0] vc_offset;
   logic        inc_pulse, dec_pulse, adj_reject, ptr_invalid;

   always #10 clk = ~clk;

   au4_ptr_interp dut (
      .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .ptr_word(ptr_word),
      .active_ptr(active_ptr), .vc_offset(vc_offset), .inc_pulse(inc_pulse),
      .dec_pulse(dec_pulse), .adj_reject(adj_reject), .ptr_invalid(ptr_invalid)
   );

   int    checks = 0;
   int    errors = 0;
   string tag = "R1";

   // behavioural reference state
   int m_act = 0, m_guard = 3, m_cand = 0, m_run = 0;
   bit m_lock = 0, m_inv = 0, m_inc = 0, m_dec = 0, m_rej = 0;

   task automatic chk(string name, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, name, act, exp);
      end
   endtask

   task automatic compare_all();
      chk("active_ptr", int'(active_ptr), m_act);
      chk("vc_offset", int'(vc_offset), 3 * m_act);
      chk("inc_pulse", int'(inc_pulse), int'(m_inc));
      chk("dec_pulse", int'(dec_pulse), int'(m_dec));
      chk("adj_reject", int'(adj_reject), int'(m_rej));
      chk("ptr_invalid", int'(ptr_invalid), int'(m_inv));
   endtask

   function automatic int bump(int g);
      return (g < 3) ? g + 1 : 3;
   endfunction

   task automatic model(bit s, logic [15:0] w);
      int v, ci, cd, kind;
      m_inc = 0; m_dec = 0; m_rej = 0;
      if (!s) return;
      v = int'(w[9:0]);
      ci = 0; cd = 0;
      for (int k = 0; k < 5; k++) begin
         if (((v ^ m_act) >> (2 * k + 1)) & 1) ci++;
         if (((v ^ m_act) >> (2 * k)) & 1) cd++;
      end
      if (m_lock && ci >= 3 && cd < 3) kind = 1;
      else if (m_lock && cd >= 3 && ci < 3) kind = 2;
      else if (v > 782) kind = 3;
      else if (m_lock && v == m_act) kind = 0;
      else kind = 4;
      m_inv = (kind == 3);
      if (kind == 1 || kind == 2) begin
         m_run = 0;
         if (m_guard >= 3) begin
            m_guard = 0;
            if (kind == 1) begin m_act = (m_act == 782) ? 0 : m_act + 1; m_inc = 1; end
            else begin m_act = (m_act == 0) ? 782 : m_act - 1; m_dec = 1; end
         end else begin
            m_rej = 1;
            m_guard = bump(m_guard);
         end
      end else if (kind == 4) begin
         if (m_run > 0 && v == m_cand) m_run++;
         else begin m_cand = v; m_run = 1; end
         if (m_run == 3) begin
            m_act = v; m_lock = 1; m_run = 0; m_guard = 0;
         end else m_guard = bump(m_guard);
      end else begin
         m_run = 0;
         m_guard = bump(m_guard);
      end
   endtask

   task automatic cyc(bit s, logic [15:0] w);
      @(negedge clk);
      compare_all();
      frame_stb = s;
      ptr_word = w;
      model(s, w);
   endtask

   task automatic frm(int v);
      cyc(1'b1, 16'(v));
      cyc(1'b0, 16'h0);
   endtask

   initial begin
      #(20 * 150000);
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      tag = "R1";
      cyc(1'b0, 16'h0);
      // R9: inversion-looking words before lock are plain values
      tag = "R9";
      frm(87 ^ 16'h155); frm(87 ^ 16'h155);
      // R2: interrupted run, then a full run of three
      tag = "R2";
      frm(87); frm(87); frm(90); frm(87); frm(87);
      frm(87); // third consecutive: accepted, offset 261 (R5)
      tag = "R5";
      cyc(1'b0, 16'h0);
      // R8: steady frames and idle cycles
      tag = "R8";
      frm(87); frm(87); frm(87);
      repeat (4) cyc(1'b0, 16'hFFFF);
      // R4: decrement 87 -> 86, offset 258
      tag = "R4";
      frm(87 ^ 16'h155);
      // R6: immediate increment is rejected
      tag = "R6";
      frm(86 ^ 16'h2AA);
      frm(86); frm(86);
      tag = "R3";
      frm(86 ^ 16'h2AA); // gap now 3: accepted, back to 87
      // R7: out-of-range word with both majorities flipped
      tag = "R7";
      frm(100); frm(100); frm(87 ^ 16'h3FF); frm(100); frm(87);
      frm(87 ^ 16'h3FF); frm(87);
      // wrap points
      tag = "R3";
      frm(782); frm(782); frm(782); frm(782); frm(782); frm(782);
      frm(782 ^ 16'h2AA);
      tag = "R4";
      frm(0); frm(0); frm(0);
      frm(0 ^ 16'h155);
      // randomised mix, guard windows exercised by gap lengths
      tag = "R6";
      begin
         int tgt = 400;
         for (int n = 0; n < 3000; n++) begin
            int r = int'($urandom % 10);
            logic [5:0] hi = 6'($urandom);
            if (($urandom % 40) == 0) tgt = int'($urandom % 783);
            case (r)
               0, 1, 2: cyc(1'b1, {hi, 10'(tgt)});
               3:       cyc(1'b1, {hi, 10'(m_act ^ 16'h2AA)});
               4:       cyc(1'b1, {hi, 10'(m_act ^ 16'h155)});
               5:       cyc(1'b1, {hi, 10'($urandom)});
               6, 7:    cyc(1'b1, {hi, 10'(m_act)});
               default: cyc(1'b0, {hi, 10'($urandom)});
            endcase
         end
      end
      tag = "R8";
      cyc(1'b0, 16'h0);
      cyc(1'b0, 16'h0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule